// File: doc/BRIEF.md
# Serial Memory Write Guard

This block keeps the status word of a serial nonvolatile memory and decides, cycle by cycle, whether a write to the storage array or to the status word may go ahead. An SPI front end decodes the commands and hands over one-cycle strobes. The block also receives the active-low protect pin, the byte address that the front end is about to write, and a busy level from the self-timed write engine. It returns the status byte for readback, a permit for an array write at the presented address, and a permit for a status write.

The protection bits (a sticky protect-enable bit and a two-bit lock field) live in flops. A soft reset leaves them alone. A power-on reset clears them. A status write only records the new values. They take effect when the write engine finishes its cycle, which is the falling edge of busy. The write-enable latch and the user flag are volatile and start cleared.

Top module: `spi_wp_guard`

## Requirements
- R1: The status byte reads, from bit 7 down to bit 0: protect-enable, flag, 1, 1, lock[1], lock[0], write-enable latch, and busy. Bit 0 follows `wr_busy` in the same cycle.
- R2: After a power-on reset with `wr_busy` low, the status byte is 0x30 and both permits are 0.
- R3: `cmd_wren` sets the write-enable latch and `cmd_wrdi` clears it. When both arrive in the same cycle, the clear wins. The change shows from the next cycle.
- R4: `cmd_sflb` sets the flag and `cmd_wrdi` clears it. The status data byte never changes the flag.
- R5: While the write-enable latch is 0, `arr_wr_ok` and `sr_wr_ok` are both 0.
- R6: The lock field protects these address ranges of the 12-bit array: 00 protects nothing, 01 protects 0xC00-0xFFF, 10 protects 0x800-0xFFF, and 11 protects every address. `arr_wr_ok` is the write-enable latch ANDed with "address not protected".
- R7: `sr_wr_ok` is 0 when protect-enable is 1 and `prot_n` is low. When protect-enable is 0, `prot_n` has no effect and `sr_wr_ok` equals the latch. Unlocked array addresses stay writable in either case.
- R8: A `cmd_wrsr` strobe accepted while `sr_wr_ok` is 1 keeps data bits 7, 3 and 2 as the new protect-enable and lock bits. These bits appear only at the first clock where `wr_busy` has fallen, and no earlier. Data bits 6, 5, 4, 1 and 0 are ignored.
- R9: Driving `prot_n` low while an accepted status write is still busy does not cancel it. Only later status writes are refused.
- R10: The write-enable latch clears at the clock that sees `wr_busy` fall.
- R11: `soft_rst` clears the latch, the flag and any pending status write. It keeps protect-enable and the lock bits.
- R12: A `cmd_wrsr` strobe that arrives while `sr_wr_ok` is 0 leaves protect-enable and the lock bits unchanged after the following busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears everything |
| soft_rst | input | 1 | Soft reset, synchronous, active high, clears volatile state only |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable / clear-flag command strobe |
| cmd_sflb | input | 1 | Set-flag command strobe |
| cmd_wrsr | input | 1 | Status-write strobe, qualified by `wrsr_data` |
| wrsr_data | input | 8 | Status data byte received with `cmd_wrsr` |
| prot_n | input | 1 | Protect pin, active low |
| arr_addr | input | 12 | Byte address of the intended array write |
| wr_busy | input | 1 | Write engine busy level |
| status_byte | output | 8 | Status byte for readback |
| arr_wr_ok | output | 1 | Array write allowed at `arr_addr` |
| sr_wr_ok | output | 1 | Status write allowed |

## Verification
A wrong protection state appears at the ports in two ways. Directly, it is visible in bits 7, 3 and 2 of the status byte, one clock after the commit edge. Indirectly, it is visible in the combinational permits, in the same cycle that the address or pin is presented. The bench walks every lock code across addresses on both sides of the quarter and half boundaries. It reads the status byte while busy is high to catch an early commit, and after the fall to catch a late or missing commit. Pin behaviour is checked with protect-enable both set and clear. One case drops the pin during a running status write.

// File: rtl/mguard_pkg.sv
package mguard_pkg;

    localparam int STAT_W = 8;

    typedef struct packed {
        logic       wpen;
        logic [1:0] lock;
    } nv_bits_t;

    typedef struct packed {
        logic     valid;
        nv_bits_t bits;
    } nv_pend_t;

    // returns 1 when the address falls in the region the lock code covers
    function automatic logic lock_hit(input logic [1:0] lock, input logic [1:0] top2);
        logic hit;
        case (lock)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input nv_bits_t nv, input logic flag,
                                                      input logic wel, input logic busy);
        return {nv.wpen, flag, 2'b11, nv.lock, wel, busy};
    endfunction

endpackage

// File: rtl/mguard_volatile.sv
module mguard_volatile (
    input  logic clk,
    input  logic por,
    input  logic soft_rst,
    input  logic cmd_wren,
    input  logic cmd_wrdi,
    input  logic cmd_sflb,
    input  logic commit,
    output logic wel,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (por || soft_rst) begin
            wel  <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (cmd_wrdi || commit)
                wel <= 1'b0;
            else if (cmd_wren)
                wel <= 1'b1;

            if (cmd_wrdi)
                flag <= 1'b0;
            else if (cmd_sflb)
                flag <= 1'b1;
        end
    end
endmodule

// File: rtl/mguard_nvbits.sv
module mguard_nvbits
    import mguard_pkg::*;
(
    input  logic        clk,
    input  logic        por,
    input  logic        soft_rst,
    input  logic        cmd_wrsr,
    input  logic [7:0]  wrsr_data,
    input  logic        sr_ok,
    input  logic        wr_busy,
    output logic        commit,
    output nv_bits_t    nv
);
    nv_pend_t pend;
    logic     busy_q;
    logic     unused_data_bits;

    assign unused_data_bits = ^{wrsr_data[6:4], wrsr_data[1:0]};
    assign commit = busy_q && !wr_busy;

    always_ff @(posedge clk) begin
        if (por) begin
            nv     <= '0;
            pend   <= '0;
            busy_q <= 1'b0;
        end else begin
            busy_q <= wr_busy;
            if (soft_rst) begin
                pend.valid <= 1'b0;
            end else begin
                if (commit && pend.valid) begin
                    nv         <= pend.bits;
                    pend.valid <= 1'b0;
                end
                if (cmd_wrsr && sr_ok) begin
                    pend.valid     <= 1'b1;
                    pend.bits.wpen <= wrsr_data[7];
                    pend.bits.lock <= wrsr_data[3:2];
                end
            end
        end
    end
endmodule

// File: rtl/mguard_permit.sv
module mguard_permit
    import mguard_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  nv_bits_t          nv,
    input  logic              wel,
    input  logic              prot_n,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic              arr_ok,
    output logic              sr_ok
);
    localparam int TOP = ADDR_W - 1;

    logic locked;
    assign locked = lock_hit(nv.lock, arr_addr[TOP -: 2]);
    assign arr_ok = wel && !locked;
    assign sr_ok  = wel && !(nv.wpen && !prot_n);
endmodule

// File: rtl/spi_wp_guard.sv
module spi_wp_guard
    import mguard_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              por,
    input  logic              soft_rst,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_sflb,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              prot_n,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              wr_busy,
    output logic [7:0]        status_byte,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok
);
    nv_bits_t nv;
    logic     commit;
    logic     wel;
    logic     flag;

    mguard_volatile u_vol (
        .clk(clk), .por(por), .soft_rst(soft_rst),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_sflb(cmd_sflb),
        .commit(commit), .wel(wel), .flag(flag)
    );

    mguard_nvbits u_nv (
        .clk(clk), .por(por), .soft_rst(soft_rst),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .sr_ok(sr_wr_ok),
        .wr_busy(wr_busy), .commit(commit), .nv(nv)
    );

    mguard_permit #(.ADDR_W(ADDR_W)) u_perm (
        .nv(nv), .wel(wel), .prot_n(prot_n), .arr_addr(arr_addr),
        .arr_ok(arr_wr_ok), .sr_ok(sr_wr_ok)
    );

    assign status_byte = pack_status(nv, flag, wel, wr_busy);
endmodule

// File: rtl/mguard_chk.sv
module mguard_chk (
    input logic       clk,
    input logic       por,
    input logic       soft_rst,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_sflb,
    input logic       prot_n,
    input logic       wr_busy,
    input logic [7:0] status_byte,
    input logic       arr_wr_ok,
    input logic       sr_wr_ok
);
    logic busy_prev;
    always_ff @(posedge clk) begin
        if (por) busy_prev <= 1'b0;
        else     busy_prev <= wr_busy;
    end

    // R5
    wel_gate_chk: assert property (@(posedge clk) disable iff (por)
        !status_byte[1] |-> (!arr_wr_ok && !sr_wr_ok));

    // R7
    pin_lock_chk: assert property (@(posedge clk) disable iff (por)
        (status_byte[7] && !prot_n) |-> !sr_wr_ok);

    // R3
    wel_clear_chk: assert property (@(posedge clk) disable iff (por)
        cmd_wrdi |=> !status_byte[1]);

    // R3
    wel_set_chk: assert property (@(posedge clk) disable iff (por)
        (cmd_wren && !cmd_wrdi && !soft_rst && !(busy_prev && !wr_busy)) |=> status_byte[1]);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (por)
        (cmd_sflb && !cmd_wrdi && !soft_rst) |=> status_byte[6]);

    // R6
    full_lock_chk: assert property (@(posedge clk) disable iff (por)
        (status_byte[3:2] == 2'b11) |-> !arr_wr_ok);

    // R8
    commit_only_chk: assert property (@(posedge clk) disable iff (por)
        !(busy_prev && !wr_busy) |=> ($stable(status_byte[7]) && $stable(status_byte[3:2])));

    // R11
    soft_clear_chk: assert property (@(posedge clk) disable iff (por)
        soft_rst |=> (!status_byte[1] && !status_byte[6]));
endmodule

bind spi_wp_guard mguard_chk u_chk (
    .clk(clk), .por(por), .soft_rst(soft_rst),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_sflb(cmd_sflb),
    .prot_n(prot_n), .wr_busy(wr_busy), .status_byte(status_byte),
    .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok)
);

// File: tb/tb_spi_wp_guard.sv
module tb_spi_wp_guard;
    logic        clk = 1'b0;
    logic        por, soft_rst, cmd_wren, cmd_wrdi, cmd_sflb, cmd_wrsr, prot_n, wr_busy;
    logic [7:0]  wrsr_data;
    logic [11:0] arr_addr;
    logic [7:0]  status_byte;
    logic        arr_wr_ok, sr_wr_ok;

    int total = 0;
    int bad   = 0;
    logic       e_wpen = 1'b0;
    logic [1:0] e_lock = 2'b00;

    always #2 clk = ~clk;

    spi_wp_guard dut (
        .clk(clk), .por(por), .soft_rst(soft_rst),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_sflb(cmd_sflb),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .prot_n(prot_n),
        .arr_addr(arr_addr), .wr_busy(wr_busy),
        .status_byte(status_byte), .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat(input logic flag, input logic wel, input logic busy);
        return {e_wpen, flag, 2'b11, e_lock, wel, busy};
    endfunction

    // R6 region model
    function automatic logic prot_hit(input logic [1:0] lk, input logic [11:0] a);
        case (lk)
            2'b00:   return 1'b0;
            2'b01:   return a >= 12'hC00;
            2'b10:   return a >= 12'h800;
            default: return 1'b1;
        endcase
    endfunction

    task automatic tick(); @(negedge clk); endtask

    task automatic pulse_wren(); cmd_wren = 1'b1; tick(); cmd_wren = 1'b0; endtask

    // full status write: wren, strobe, busy window, fall; returns after commit edge
    task automatic sr_write(input logic [7:0] d, input logic drop_pin);
        pulse_wren();
        cmd_wrsr = 1'b1; wrsr_data = d; tick(); cmd_wrsr = 1'b0;
        wr_busy = 1'b1;
        tick();
        if (drop_pin) prot_n = 1'b0;
        tick();
        wr_busy = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        por = 1'b1; tick(); tick(); por = 1'b0; tick();
        e_wpen = 1'b0; e_lock = 2'b00;
        check("R2 status", status_byte, 8'h30);
        check("R2 arr_ok", {7'b0, arr_wr_ok}, 8'h0);
        check("R2 sr_ok", {7'b0, sr_wr_ok}, 8'h0);
    endtask

    task automatic t_latch();
        pulse_wren();
        check("R3 wren sets", status_byte, exp_stat(0, 1, 0));
        check("R6 unlocked arr_ok", {7'b0, arr_wr_ok}, 8'h1);
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
        check("R3 wrdi clears", status_byte, exp_stat(0, 0, 0));
        check("R5 arr_ok no wel", {7'b0, arr_wr_ok}, 8'h0);
        pulse_wren();
        cmd_wren = 1'b1; cmd_wrdi = 1'b1; tick(); cmd_wren = 1'b0; cmd_wrdi = 1'b0;
        check("R3 clear wins", status_byte, exp_stat(0, 0, 0));
    endtask

    task automatic t_flag();
        cmd_sflb = 1'b1; tick(); cmd_sflb = 1'b0;
        check("R4 flag set", status_byte, exp_stat(1, 0, 0));
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
        check("R4 flag clear", status_byte, exp_stat(0, 0, 0));
    endtask

    task automatic t_busy_and_commit();
        pulse_wren();
        cmd_wrsr = 1'b1; wrsr_data = 8'b0111_1011; tick(); cmd_wrsr = 1'b0;
        wr_busy = 1'b1; #1;
        check("R1 wip mirrors busy", status_byte, exp_stat(0, 1, 1));
        tick(); tick();
        check("R8 not before commit", status_byte, exp_stat(0, 1, 1));
        wr_busy = 1'b0; tick();
        e_lock = 2'b10;
        check("R8 R10 after commit", status_byte, exp_stat(0, 0, 0));
    endtask

    task automatic t_lock_map();
        logic [11:0] probes [6] = '{12'h000, 12'h7FF, 12'h800, 12'hBFF, 12'hC00, 12'hFFF};
        for (int lk = 0; lk < 4; lk++) begin
            sr_write({4'b0000, lk[1:0], 2'b00}, 1'b0);
            e_lock = lk[1:0];
            check("R8 lock field", status_byte, exp_stat(0, 0, 0));
            pulse_wren();
            for (int p = 0; p < 6; p++) begin
                arr_addr = probes[p]; #1;
                check("R6 region", {7'b0, arr_wr_ok}, {7'b0, !prot_hit(lk[1:0], probes[p])});
            end
            cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
        end
    endtask

    task automatic t_pin();
        sr_write(8'h84, 1'b0);
        e_wpen = 1'b1; e_lock = 2'b01;
        check("R8 wpen set", status_byte, exp_stat(0, 0, 0));
        pulse_wren();
        prot_n = 1'b1; #1;
        check("R7 pin high ok", {7'b0, sr_wr_ok}, 8'h1);
        prot_n = 1'b0; #1;
        check("R7 pin low refused", {7'b0, sr_wr_ok}, 8'h0);
        arr_addr = 12'h100; #1;
        check("R7 unlocked still writable", {7'b0, arr_wr_ok}, 8'h1);
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
        prot_n = 1'b1;
        sr_write(8'h08, 1'b0);
        e_wpen = 1'b0; e_lock = 2'b10;
        check("R8 wpen cleared", status_byte, exp_stat(0, 0, 0));
        pulse_wren();
        prot_n = 1'b0; #1;
        check("R7 pin ignored", {7'b0, sr_wr_ok}, 8'h1);
        cmd_wrdi = 1'b1; tick(); cmd_wrdi = 1'b0;
        prot_n = 1'b1;
    endtask

    task automatic t_no_abort_and_refuse();
        sr_write(8'h80, 1'b0);
        e_wpen = 1'b1; e_lock = 2'b00;
        sr_write(8'h84, 1'b1);
        e_lock = 2'b01;
        check("R9 running write completes", status_byte, exp_stat(0, 0, 0));
        pulse_wren();
        check("R9 later write refused", {7'b0, sr_wr_ok}, 8'h0);
        cmd_wrsr = 1'b1; wrsr_data = 8'h0C; tick(); cmd_wrsr = 1'b0;
        wr_busy = 1'b1; tick(); wr_busy = 1'b0; tick();
        check("R12 refused write no effect", status_byte, exp_stat(0, 0, 0));
    endtask

    task automatic t_soft();
        cmd_sflb = 1'b1; tick(); cmd_sflb = 1'b0;
        pulse_wren();
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        check("R11 soft keeps nv", status_byte, exp_stat(0, 0, 0));
        por = 1'b1; tick(); por = 1'b0; tick();
        e_wpen = 1'b0; e_lock = 2'b00;
        check("R2 por clears nv", status_byte, 8'h30);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        por = 1'b1; soft_rst = 1'b0; cmd_wren = 1'b0; cmd_wrdi = 1'b0;
        cmd_sflb = 1'b0; cmd_wrsr = 1'b0; wrsr_data = 8'h00; prot_n = 1'b1;
        arr_addr = 12'h000; wr_busy = 1'b0;
        tick();
        t_reset();
        t_latch();
        t_flag();
        t_busy_and_commit();
        t_lock_map();
        t_pin();
        t_no_abort_and_refuse();
        t_soft();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule